// File: doc/BRIEF.md
# PCI Inbound DMA Window Decoder

This block sits behind the PCI target logic. For every inbound DMA address phase it decides which address window the address falls in, and what happens to the access. The address phase is either a single-address cycle carrying a 32-bit address or a dual-address cycle carrying a 64-bit address. For a dual-address cycle, the upper half of the address arrives in one of two ways. With a 64-bit request it is on the upper lanes in the same cycle. Without one it is on the lower lanes in the following cycle. The block assembles the complete address before decoding it.

There are four programmable windows. Each has a base, a size mask, a translated base and three control bits: enable, scatter-gather select and dual-address permission. A direct-mapped hit yields a system address. A scatter-gather hit yields a translation request that carries the offset within the window. The page-table walker consumes that request.

Beside the programmable windows sits a fixed high-memory window for dual-address cycles. It passes the low 35 address bits through unchanged. A single global control bit gates this window. One registered result appears in the cycle after the last address cycle.

Top module: `pci_dma_win_dec`

## Requirements
- R1: A single-address cycle hits window i when the window is enabled and (address AND NOT mask) equals its base. A window whose enable bit is clear never hits.
- R2: A hit in a direct-mapped window (sg bit 0) gives `res_addr` = translated base OR (address AND mask), with `res_sg_req` low.
- R3: A hit in a scatter-gather window (sg bit 1) raises `res_sg_req` and gives `res_addr` = address AND mask, which is the window offset.
- R4: When several programmable windows hit, the lowest-numbered one is reported in `res_win`.
- R5: An address that hits nothing gives `res_miss`=1 with `res_hit`, `res_sg_req` and `res_fixed` all 0, and `res_addr`=0. While `res_valid` is low, all result flags are 0.
- R6: On a dual-address cycle with the fixed window enabled, an address whose bits 63:40 equal 0x000001 hits the fixed window. The hit gives `res_fixed`=1, `res_win`=0 and `res_addr` = address bits 34:0. Bits 39:35 are ignored.
- R7: With the fixed-window enable cleared, a dual-address cycle is decoded only by the programmable windows.
- R8: With `ap_req64` high, a dual-address cycle takes address bits 63:32 from `ad_hi` in the same cycle. With `ap_req64` low, it takes them from `ad_lo` in the next cycle. `ad_hi` is ignored on single-address cycles.
- R9: On a dual-address cycle, only window 3 can hit, and only when its dual-address bit is set. It decodes the low 32 address bits. The fixed window takes priority over window 3.
- R10: `res_valid` pulses for one cycle, in the cycle after the final address cycle. After reset, all outputs are 0 and all windows and the fixed window are disabled.
- R11: Configuration writes are addressed by `cfg_addr`. With bit 4 set, data bit 0 is the fixed-window enable. With bit 4 clear, bits 3:2 select the window and bits 1:0 select the field. Field 0 is the base, 1 the mask, 2 the translated base, and 3 the control word. In the control word, bit 0 is enable, bit 1 is sg and bit 2 is the dual-address permission, which only window 3 keeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register select |
| cfg_wdata | input | 35 | Configuration write data |
| ap_valid | input | 1 | First address cycle present |
| ap_dac | input | 1 | Address phase is a dual-address cycle |
| ap_req64 | input | 1 | 64-bit request asserted with the first cycle |
| ad_lo | input | 32 | Address lanes 31:0 |
| ad_hi | input | 32 | Address lanes 63:32 |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | Some window hit |
| res_miss | output | 1 | No window hit |
| res_fixed | output | 1 | Fixed high-memory window hit |
| res_win | output | 2 | Winning programmable window |
| res_sg_req | output | 1 | Scatter-gather translation requested |
| res_addr | output | 35 | System address, or window offset when `res_sg_req` is set |

## Verification
The bench uses overlapping windows 1 and 3, so a priority encoder that picks the highest hit returns window 3 where window 1 is expected. The lane that must not be used carries garbage. A split dual-address cycle that read `ad_hi`, or a single-address cycle that read it, would therefore produce a wrong address or a miss. Dual-address cycles aimed at window 0 ranges and at window 3 with the fixed window cleared catch a decoder that lets low windows see 64-bit addresses or ignores the enable. A fixed-window address with nonzero bits 39:35 exposes a pass-through that is too wide.

// File: rtl/pdw_pkg.sv
package pdw_pkg;
  parameter int PCI_AW   = 32;
  parameter int SYS_AW   = 35;
  parameter int NWIN     = 4;
  parameter int DAC_WIN  = 3;
  parameter int FIX_LSB  = 40;
  parameter logic [63-FIX_LSB:0] FIX_TAG = 24'h000001;
  localparam int WIN_IW  = $clog2(NWIN);
  localparam int CFG_AW  = WIN_IW + 3;

  typedef enum logic [1:0] {FLD_BASE, FLD_MASK, FLD_XLATE, FLD_CTRL} cfg_field_e;

  typedef struct packed {
    logic [PCI_AW-1:0] base;
    logic [PCI_AW-1:0] mask;
    logic [SYS_AW-1:0] xlate;
    logic              en;
    logic              sg;
    logic              dac;
  } win_cfg_t;

  // window hit: address with size bits cleared equals base
  function automatic logic win_hits(input logic [PCI_AW-1:0] a,
                                    input logic [PCI_AW-1:0] base,
                                    input logic [PCI_AW-1:0] mask);
    return (a & ~mask) == base;
  endfunction

  function automatic logic [SYS_AW-1:0] win_offset(input logic [PCI_AW-1:0] a,
                                                   input logic [PCI_AW-1:0] mask);
    return SYS_AW'(a & mask);
  endfunction

  function automatic logic [SYS_AW-1:0] direct_map(input logic [SYS_AW-1:0] xlate,
                                                   input logic [PCI_AW-1:0] a,
                                                   input logic [PCI_AW-1:0] mask);
    return xlate | win_offset(a, mask);
  endfunction

  function automatic logic fixed_match(input logic [63:0] a);
    return a[63:FIX_LSB] == FIX_TAG;
  endfunction
endpackage

// File: rtl/pdw_capture.sv
module pdw_capture
  import pdw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ap_valid,
  input  logic        ap_dac,
  input  logic        ap_req64,
  input  logic [31:0] ad_lo,
  input  logic [31:0] ad_hi,
  output logic        addr_done,
  output logic        addr_dac,
  output logic [63:0] cap_addr
);
  logic        hold_q;
  logic [31:0] low_q;
  logic        split_start;

  assign split_start = ap_valid && ap_dac && !ap_req64 && !hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      low_q  <= '0;
    end else begin
      hold_q <= split_start;
      if (split_start) low_q <= ad_lo;
    end
  end

  always_comb begin
    addr_done = 1'b0;
    addr_dac  = 1'b0;
    cap_addr  = '0;
    if (hold_q) begin
      addr_done = 1'b1;
      addr_dac  = 1'b1;
      cap_addr  = {ad_lo, low_q};
    end else if (ap_valid && !split_start) begin
      addr_done = 1'b1;
      addr_dac  = ap_dac;
      cap_addr  = ap_dac ? {ad_hi, ad_lo} : {32'h0, ad_lo};
    end
  end

  // R8: a split dual-address cycle completes on the following cycle
  a_r8_split_next: assert property (@(posedge clk) disable iff (!rst_n)
    split_start |=> addr_done && addr_dac);
  // R8: with 64-bit request the upper half comes from the upper lanes
  a_r8_req64_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_valid && ap_dac && ap_req64 && !hold_q) |-> addr_done && cap_addr[63:32] == ad_hi);
endmodule

// File: rtl/pdw_win_regs.sv
module pdw_win_regs
  import pdw_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [SYS_AW-1:0]       cfg_wdata,
  output win_cfg_t [NWIN-1:0]     cfg,
  output logic                    fixed_en
);
  logic       glb_sel;
  cfg_field_e fld;

  assign glb_sel = cfg_addr[CFG_AW-1];
  assign fld     = cfg_field_e'(cfg_addr[1:0]);

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic wsel;
    assign wsel = cfg_we && !glb_sel && (cfg_addr[2 +: WIN_IW] == WIN_IW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg[i] <= '0;
      end else if (wsel) begin
        case (fld)
          FLD_BASE:  cfg[i].base  <= cfg_wdata[PCI_AW-1:0];
          FLD_MASK:  cfg[i].mask  <= cfg_wdata[PCI_AW-1:0];
          FLD_XLATE: cfg[i].xlate <= cfg_wdata;
          default: begin
            cfg[i].en  <= cfg_wdata[0];
            cfg[i].sg  <= cfg_wdata[1];
            cfg[i].dac <= (i == DAC_WIN) ? cfg_wdata[2] : 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                fixed_en <= 1'b0;
    else if (cfg_we && glb_sel) fixed_en <= cfg_wdata[0];
  end
endmodule

// File: rtl/pdw_win_match.sv
module pdw_win_match
  import pdw_pkg::*;
#(
  parameter int IDX = 0
)(
  input  win_cfg_t          cfg,
  input  logic [PCI_AW-1:0] lo,
  input  logic              is_dac,
  output logic              hit,
  output logic [SYS_AW-1:0] xaddr
);
  localparam bit DAC_OK = (IDX == DAC_WIN);
  logic cycle_ok;

  assign cycle_ok = is_dac ? (DAC_OK && cfg.dac) : 1'b1;
  assign hit      = cfg.en && cycle_ok && win_hits(lo, cfg.base, cfg.mask);
  assign xaddr    = cfg.sg ? win_offset(lo, cfg.mask) : direct_map(cfg.xlate, lo, cfg.mask);
endmodule

// File: rtl/pci_dma_win_dec.sv
module pci_dma_win_dec
  import pdw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [34:0]       cfg_wdata,
  input  logic              ap_valid,
  input  logic              ap_dac,
  input  logic              ap_req64,
  input  logic [31:0]       ad_lo,
  input  logic [31:0]       ad_hi,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_miss,
  output logic              res_fixed,
  output logic [1:0]        res_win,
  output logic              res_sg_req,
  output logic [34:0]       res_addr
);
  logic                          addr_done, addr_dac;
  logic [63:0]                   cap_addr;
  win_cfg_t [NWIN-1:0]           cfg;
  logic                          fixed_en;
  logic [NWIN-1:0]               hit_vec;
  logic [NWIN-1:0][SYS_AW-1:0]   xa;
  logic                          fixed_hit, any_hit;
  logic [WIN_IW-1:0]             sel;
  logic                          res_dac_q;

  pdw_capture u_cap (
    .clk, .rst_n, .ap_valid, .ap_dac, .ap_req64, .ad_lo, .ad_hi,
    .addr_done, .addr_dac, .cap_addr
  );

  pdw_win_regs u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg, .fixed_en
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_match
    pdw_win_match #(.IDX(i)) u_m (
      .cfg(cfg[i]), .lo(cap_addr[PCI_AW-1:0]), .is_dac(addr_dac),
      .hit(hit_vec[i]), .xaddr(xa[i])
    );
  end

  assign fixed_hit = addr_dac && fixed_en && fixed_match(cap_addr);
  assign any_hit   = |hit_vec;

  // lowest-numbered hit wins
  always_comb begin
    sel = '0;
    for (int i = NWIN-1; i >= 0; i--)
      if (hit_vec[i]) sel = WIN_IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !addr_done) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_miss   <= 1'b0;
      res_fixed  <= 1'b0;
      res_win    <= '0;
      res_sg_req <= 1'b0;
      res_addr   <= '0;
      res_dac_q  <= 1'b0;
    end else begin
      res_valid  <= 1'b1;
      res_dac_q  <= addr_dac;
      res_hit    <= fixed_hit || any_hit;
      res_miss   <= !(fixed_hit || any_hit);
      res_fixed  <= fixed_hit;
      res_win    <= fixed_hit ? '0 : sel;
      res_sg_req <= !fixed_hit && any_hit && cfg[sel].sg;
      res_addr   <= fixed_hit ? cap_addr[SYS_AW-1:0] : (any_hit ? xa[sel] : '0);
    end
  end

  // R10: exactly one result, one cycle after the final address cycle
  a_r10_valid_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done |=> res_valid);
  a_r10_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(addr_done));
  // R5: no flags without a result
  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !res_hit && !res_miss && !res_sg_req && !res_fixed);
  // R6: fixed window passes the low address bits unchanged
  a_r6_fixed_pass: assert property (@(posedge clk) disable iff (!rst_n)
    res_fixed |-> res_addr == $past(cap_addr[SYS_AW-1:0]));
  // R9: only the dual-address window serves 64-bit cycles
  a_r9_dac_window: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && !res_fixed && res_dac_q) |-> res_win == WIN_IW'(DAC_WIN));
  // R4: no lower-numbered window was hitting
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit && !res_fixed) |->
      ($past(hit_vec) & ~({NWIN{1'b1}} << res_win)) == '0);
endmodule

// File: tb/sim_pci_dma_win_dec.sv
`timescale 1ns/1ps
module sim_pci_dma_win_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [34:0] cfg_wdata = '0;
  logic        ap_valid = 1'b0, ap_dac = 1'b0, ap_req64 = 1'b0;
  logic [31:0] ad_lo = '0, ad_hi = '0;
  logic        res_valid, res_hit, res_miss, res_fixed, res_sg_req;
  logic [1:0]  res_win;
  logic [34:0] res_addr;

  always #2.5 clk = ~clk;

  pci_dma_win_dec u0 (.*);

  typedef struct {
    int          cyc;
    logic        hit, miss, fixed, sg;
    logic [1:0]  win;
    logic [34:0] addr;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0, fails = 0;
  bit   done = 0;

  logic [31:0] m_base[4], m_mask[4];
  logic [34:0] m_xl[4];
  logic        m_en[4], m_sg[4], m_dac[4];
  logic        m_fix = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic cfg_wr(input logic [4:0] a, input logic [34:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R11: field map {global, win[1:0], field[1:0]}
  task automatic set_win(input int w, input logic [31:0] b, input logic [31:0] m,
                         input logic [34:0] x, input logic en, input logic sg, input logic dac);
    cfg_wr({1'b0, 2'(w), 2'd0}, 35'(b));
    cfg_wr({1'b0, 2'(w), 2'd1}, 35'(m));
    cfg_wr({1'b0, 2'(w), 2'd2}, x);
    cfg_wr({1'b0, 2'(w), 2'd3}, 35'({dac, sg, en}));
    m_base[w] = b; m_mask[w] = m; m_xl[w] = x;
    m_en[w] = en; m_sg[w] = sg; m_dac[w] = (w == 3) ? dac : 1'b0;
  endtask

  task automatic set_fix(input logic en);
    cfg_wr(5'h10, 35'(en));
    m_fix = en;
  endtask

  function automatic exp_t predict(input logic dac, input logic [63:0] a, input string req);
    exp_t e;
    e.hit = 0; e.miss = 1; e.fixed = 0; e.sg = 0; e.win = 0; e.addr = 0; e.req = req; e.cyc = 0;
    if (dac && m_fix && a[63:40] == 24'h000001) begin
      e.hit = 1; e.miss = 0; e.fixed = 1; e.addr = a[34:0];
      return e;
    end
    for (int w = 0; w < 4; w++) begin
      if (dac && !(w == 3 && m_dac[3])) continue;
      if (m_en[w] && ((a[31:0] & ~m_mask[w]) == m_base[w])) begin
        e.hit = 1; e.miss = 0; e.win = 2'(w); e.sg = m_sg[w];
        e.addr = m_sg[w] ? 35'(a[31:0] & m_mask[w]) : (m_xl[w] | 35'(a[31:0] & m_mask[w]));
        return e;
      end
    end
    return e;
  endfunction

  task automatic issue(input logic dac, input logic req64, input logic [63:0] a, input string req);
    exp_t e;
    e = predict(dac, a, req);
    @(negedge clk);
    ap_valid = 1'b1; ap_dac = dac; ap_req64 = req64;
    ad_lo = a[31:0];
    ad_hi = (dac && req64) ? a[63:32] : 32'hDEAD_BEEF;
    e.cyc = cyc + ((dac && !req64) ? 2 : 1);
    exp_q.push_back(e);
    if (dac && !req64) begin
      @(negedge clk);
      ap_valid = 1'b0; ad_lo = a[63:32]; ad_hi = 32'hCAFE_F00D;
    end
    @(negedge clk);
    ap_valid = 1'b0; ap_dac = 1'b0; ap_req64 = 1'b0; ad_lo = '0; ad_hi = '0;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (res_valid) begin
          if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R10 unexpected result: actual valid=1 expected valid=0");
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (cyc != e.cyc || res_hit != e.hit || res_miss != e.miss || res_fixed != e.fixed ||
                res_win != e.win || res_sg_req != e.sg || res_addr != e.addr) begin
              fails++;
              $display("FAIL %s actual cyc=%0d hit=%b miss=%b fix=%b win=%0d sg=%b addr=%h expected cyc=%0d hit=%b miss=%b fix=%b win=%0d sg=%b addr=%h",
                       e.req, cyc, res_hit, res_miss, res_fixed, res_win, res_sg_req, res_addr,
                       e.cyc, e.hit, e.miss, e.fixed, e.win, e.sg, e.addr);
            end
          end
        end else if (exp_q.size() != 0 && exp_q[0].cyc < cyc) begin
          exp_t e;
          e = exp_q.pop_front();
          checks++; fails++;
          $display("FAIL %s missing result: actual valid=0 expected valid=1 at cyc %0d", e.req, e.cyc);
        end
      end
    end
  end

  initial begin
    for (int w = 0; w < 4; w++) begin
      m_base[w] = 0; m_mask[w] = 0; m_xl[w] = 0; m_en[w] = 0; m_sg[w] = 0; m_dac[w] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R10 reset state
    if ({res_valid, res_hit, res_miss, res_fixed, res_win, res_sg_req, res_addr} != '0) begin
      fails++;
      $display("FAIL R10 reset outputs actual=%h expected=0",
               {res_valid, res_hit, res_miss, res_fixed, res_win, res_sg_req, res_addr});
    end
    // R11: program windows
    set_win(0, 32'h0080_0000, 32'h007F_FFFF, 35'h0, 1, 1, 0);
    set_win(1, 32'h8000_0000, 32'h3FFF_FFFF, 35'h0, 1, 0, 0);
    set_win(2, 32'hC000_0000, 32'h3FFF_FFFF, 35'h0, 1, 1, 0);
    set_win(3, 32'h8000_0000, 32'h0FFF_FFFF, 35'h4_0000_0000, 1, 0, 1);
    set_fix(1);

    issue(0, 0, 64'h0000_0000_0090_1234, "R3");        // window 0 scatter-gather
    issue(0, 0, 64'h0000_0000_8123_4560, "R4");        // windows 1 and 3 overlap
    issue(0, 0, 64'h0000_0000_BFFF_FFF0, "R2");        // window 1 direct, top edge
    issue(0, 0, 64'h0000_0000_D000_0010, "R1");        // window 2
    issue(0, 0, 64'h0000_0000_1000_0000, "R5");        // miss
    issue(1, 1, 64'h0000_01FD_8765_4321, "R6");        // fixed, upper lanes
    issue(1, 0, 64'h0000_01FD_8765_4321, "R8");        // fixed, split capture
    issue(1, 0, 64'h0000_0002_8000_0010, "R9");        // window 3 on DAC
    issue(1, 1, 64'h0000_0002_0090_0000, "R9");        // low window range on DAC misses
    set_fix(0);
    issue(1, 1, 64'h0000_01FD_8000_0020, "R7");        // falls to window 3
    issue(1, 0, 64'h0000_01FD_0090_0000, "R7");        // falls to miss
    set_win(1, 32'h8000_0000, 32'h3FFF_FFFF, 35'h0, 0, 0, 0);
    issue(0, 0, 64'h0000_0000_8123_4560, "R1");        // disabled window skipped
    set_fix(1);
    set_win(3, 32'h8000_0000, 32'h0FFF_FFFF, 35'h4_0000_0000, 1, 0, 0);
    issue(1, 1, 64'h0000_0003_8000_0000, "R9");        // DAC permission cleared
    set_win(2, 32'hC000_0000, 32'h3FFF_FFFF, 35'h0, 1, 1, 1);
    issue(1, 1, 64'h0000_0003_C000_0000, "R11");       // dual bit ignored on window 2
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL R10 results outstanding actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule